// File: doc/BRIEF.md
# Configuration Cycle Address Router

This block sits on the host I/O port of a memory-controller hub and owns the 32-bit configuration address register in processor I/O space. Software loads that register with an enable bit and a bus, device, function and dword-register selector. It then touches the four-byte data window. For each data-window access the block decides where the configuration request must go. The choices are one of the internal devices, the downstream link as a Type 0 or Type 1 cycle, or the graphics port as a Type 0 or Type 1 cycle. It presents that decision together with the selector fields to forward.

Two inputs carry the bus range that sits behind the internal graphics bridge: the secondary bus number and the subordinate bus number. Any access that the block does not turn into a configuration decision is flagged as a plain I/O pass-through to the downstream link. This covers byte or 16-bit accesses to the address register, and data-window accesses while the enable bit is clear. Packet building, link signalling and the configuration register file belong to other blocks.

Top module: `cfg_router`

## Requirements
- R1: After reset the address register reads 00000000h and both decValid and ioPass are low.
- R2: A write to I/O address 0CF8h with ioBe = 4'hF loads the address register. A read there with ioBe = 4'hF returns it combinationally on ioRdata, in the same cycle. Bit 31 is the enable, bits 23:16 the bus, 15:11 the device, 10:8 the function and 7:2 the register. Bits 30:24 and 1:0 always read 0.
- R3: An access to 0CF8h with a non-zero ioBe other than 4'hF leaves the address register unchanged and pulses ioPass for one cycle, one clock after the strobe.
- R4: An access to 0CFCh–0CFFh while the enable bit is 0 pulses ioPass one clock later and produces no decValid.
- R5: Bus 00h with device 0, 1 or 2 gives decTarget = 0 (internal).
- R6: Bus 00h with device 3 or above gives decTarget = 1 (downstream link, Type 0).
- R7: A non-zero bus that is neither equal to secBus nor in the range secBus < bus <= subBus gives decTarget = 2 (downstream link, Type 1).
- R8: A non-zero bus equal to secBus gives decTarget = 3 (graphics port, Type 0).
- R9: A bus with secBus < bus <= subBus gives decTarget = 4 (graphics port, Type 1).
- R10: An enabled data-window access pulses decValid for one cycle, one clock after the strobe. It holds decBus, decDev, decFunc and decReg from the address register and sets decWrite to 1 for a write and 0 for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | Host I/O byte address |
| ioBe | input | 4 | Byte enables |
| ioWdata | input | 32 | Write data |
| ioRd | input | 1 | Read strobe, one cycle |
| ioWr | input | 1 | Write strobe, one cycle |
| ioRdata | output | 32 | Address register read data, zero when not addressed |
| secBus | input | 8 | Secondary bus number of the graphics bridge |
| subBus | input | 8 | Subordinate bus number of the graphics bridge |
| decValid | output | 1 | One-cycle pulse: routing decision valid |
| decTarget | output | 3 | Target code (0 internal, 1 link T0, 2 link T1, 3 graphics T0, 4 graphics T1) |
| decWrite | output | 1 | Decision is for a write |
| decBus | output | 8 | Forwarded bus number |
| decDev | output | 5 | Forwarded device number |
| decFunc | output | 3 | Forwarded function number |
| decReg | output | 6 | Forwarded dword register number |
| ioPass | output | 1 | One-cycle pulse: forward as plain I/O cycle |

## Verification
Readback on ioRdata is combinational, so the bench samples it in the strobe cycle itself, 1 ns after driving the inputs. decValid, ioPass and the decision fields are registered once, so each appears exactly one clock after the strobe edge. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge. It samples once more a cycle later to confirm that the pulse has dropped.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

  typedef enum logic [2:0] {
    TGT_INTERNAL = 3'd0,
    TGT_LINK_T0  = 3'd1,
    TGT_LINK_T1  = 3'd2,
    TGT_GFX_T0   = 3'd3,
    TGT_GFX_T1   = 3'd4
  } cfgTarget_e;

  typedef struct packed {
    logic addrWrite;  // full-dword write to the address port
    logic addrRead;   // full-dword read of the address port
    logic cfgHit;     // enabled data-window access
    logic cfgWrite;   // that access is a write
    logic passHit;    // forward as plain I/O
  } ctrlStrobe_t;

endpackage

// File: rtl/cfg_router_ctrl.sv
module cfg_router_ctrl
  import cfg_router_pkg::*;
#(
  parameter int AddrWidth = 16,
  parameter logic [AddrWidth-1:0] CfgAddrPort = 16'h0CF8,
  parameter logic [AddrWidth-1:0] CfgDataPort = 16'h0CFC
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [AddrWidth-1:0] ioAddr,
  input  logic [3:0]           ioBe,
  input  logic                 ioRd,
  input  logic                 ioWr,
  input  logic                 cfgEnable,
  output ctrlStrobe_t          strobes
);

  localparam int WinLsb = 2;
  localparam logic [3:0] FullBe = '1;

  logic addrHit, dataHit, fullDw, anyAccess;

  always_comb begin
    addrHit   = (ioAddr == CfgAddrPort);
    dataHit   = (ioAddr[AddrWidth-1:WinLsb] == CfgDataPort[AddrWidth-1:WinLsb]);
    fullDw    = (ioBe == FullBe);
    anyAccess = (ioRd || ioWr) && (ioBe != '0);

    strobes.addrWrite = addrHit && fullDw && ioWr;
    strobes.addrRead  = addrHit && fullDw && ioRd;
    strobes.cfgHit    = anyAccess && dataHit && cfgEnable;
    strobes.cfgWrite  = ioWr;
    strobes.passHit   = anyAccess && ((addrHit && !fullDw) || (dataHit && !cfgEnable));
  end

  // R4: a window access is either a decision or a pass-through, never both
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.cfgHit && strobes.passHit));

  // R3: a partial access to the address port never becomes a register write
  a_r3_partial_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit && !fullDw) |-> !strobes.addrWrite);

endmodule

// File: rtl/cfg_router_dp.sv
module cfg_router_dp
  import cfg_router_pkg::*;
#(
  parameter int BusWidth       = 8,
  parameter int DevWidth       = 5,
  parameter int FuncWidth      = 3,
  parameter int RegWidth       = 6,
  parameter int NumInternalDev = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobes,
  input  logic [31:0]          ioWdata,
  input  logic [BusWidth-1:0]  secBus,
  input  logic [BusWidth-1:0]  subBus,
  output logic [31:0]          ioRdata,
  output logic                 cfgEnable,
  output logic                 decValid,
  output cfgTarget_e           decTarget,
  output logic                 decWrite,
  output logic [BusWidth-1:0]  decBus,
  output logic [DevWidth-1:0]  decDev,
  output logic [FuncWidth-1:0] decFunc,
  output logic [RegWidth-1:0]  decReg,
  output logic                 ioPass
);

  localparam int RegLsb  = 2;
  localparam int FuncLsb = RegLsb + RegWidth;
  localparam int DevLsb  = FuncLsb + FuncWidth;
  localparam int BusLsb  = DevLsb + DevWidth;
  localparam int BusTop  = BusLsb + BusWidth;
  localparam int EnBit   = 31;
  localparam logic [31:0] FieldMask =
    ((32'h1 << BusTop) - 32'h1) & ~((32'h1 << RegLsb) - 32'h1);
  localparam logic [31:0] KeepMask = (32'h1 << EnBit) | FieldMask;
  localparam logic [DevWidth-1:0] IntDevLimit = DevWidth'(NumInternalDev);

  logic [31:0]          addrWord;
  logic [BusWidth-1:0]  selBus;
  logic [DevWidth-1:0]  selDev;
  logic [FuncWidth-1:0] selFunc;
  logic [RegWidth-1:0]  selReg;
  cfgTarget_e           route;

  always_ff @(posedge clk) begin
    if (!rstN) addrWord <= '0;
    else if (strobes.addrWrite) addrWord <= ioWdata & KeepMask;
  end

  always_comb begin
    cfgEnable = addrWord[EnBit];
    selBus    = addrWord[BusLsb +: BusWidth];
    selDev    = addrWord[DevLsb +: DevWidth];
    selFunc   = addrWord[FuncLsb +: FuncWidth];
    selReg    = addrWord[RegLsb +: RegWidth];
    ioRdata   = strobes.addrRead ? addrWord : '0;
  end

  always_comb begin
    if (selBus == '0)
      route = (selDev < IntDevLimit) ? TGT_INTERNAL : TGT_LINK_T0;
    else if (selBus == secBus)
      route = TGT_GFX_T0;
    else if ((selBus > secBus) && (selBus <= subBus))
      route = TGT_GFX_T1;
    else
      route = TGT_LINK_T1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      ioPass    <= 1'b0;
      decTarget <= TGT_INTERNAL;
      decWrite  <= 1'b0;
      decBus    <= '0;
      decDev    <= '0;
      decFunc   <= '0;
      decReg    <= '0;
    end else begin
      decValid <= strobes.cfgHit;
      ioPass   <= strobes.passHit;
      if (strobes.cfgHit) begin
        decTarget <= route;
        decWrite  <= strobes.cfgWrite;
        decBus    <= selBus;
        decDev    <= selDev;
        decFunc   <= selFunc;
        decReg    <= selReg;
      end
    end
  end

  // R2: reserved and low bits never read back as one
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdata & ~KeepMask) == '0);

  // R3: a pass-through access leaves the address register alone
  a_r3_no_update: assert property (@(posedge clk) disable iff (!rstN)
    strobes.passHit |=> $stable(addrWord));

  // R5: an internal decision always names bus 0 and a low device number
  a_r5_internal: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decTarget == TGT_INTERNAL) |-> (decBus == '0 && decDev < IntDevLimit));

  // R8: graphics Type 0 names the secondary bus seen at the strobe
  a_r8_gfx_t0: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decTarget == TGT_GFX_T0) |-> (decBus != '0 && decBus == $past(secBus)));

  // R9: graphics Type 1 lies strictly above secondary and within subordinate
  a_r9_gfx_t1: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decTarget == TGT_GFX_T1) |->
      (decBus > $past(secBus) && decBus <= $past(subBus)));

  // R10: a decision and a pass-through never share a cycle
  a_r10_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    !(decValid && ioPass));

endmodule

// File: rtl/cfg_router.sv
module cfg_router
  import cfg_router_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] ioAddr,
  input  logic [3:0]  ioBe,
  input  logic [31:0] ioWdata,
  input  logic        ioRd,
  input  logic        ioWr,
  output logic [31:0] ioRdata,
  input  logic [7:0]  secBus,
  input  logic [7:0]  subBus,
  output logic        decValid,
  output logic [2:0]  decTarget,
  output logic        decWrite,
  output logic [7:0]  decBus,
  output logic [4:0]  decDev,
  output logic [2:0]  decFunc,
  output logic [5:0]  decReg,
  output logic        ioPass
);

  ctrlStrobe_t strobes;
  logic        cfgEnable;
  cfgTarget_e  targetW;

  cfg_router_ctrl #(
    .AddrWidth  (16),
    .CfgAddrPort(16'h0CF8),
    .CfgDataPort(16'h0CFC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ioAddr   (ioAddr),
    .ioBe     (ioBe),
    .ioRd     (ioRd),
    .ioWr     (ioWr),
    .cfgEnable(cfgEnable),
    .strobes  (strobes)
  );

  cfg_router_dp #(
    .BusWidth      (8),
    .DevWidth      (5),
    .FuncWidth     (3),
    .RegWidth      (6),
    .NumInternalDev(3)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .ioWdata  (ioWdata),
    .secBus   (secBus),
    .subBus   (subBus),
    .ioRdata  (ioRdata),
    .cfgEnable(cfgEnable),
    .decValid (decValid),
    .decTarget(targetW),
    .decWrite (decWrite),
    .decBus   (decBus),
    .decDev   (decDev),
    .decFunc  (decFunc),
    .decReg   (decReg),
    .ioPass   (ioPass)
  );

  assign decTarget = targetW;

endmodule

// File: tb/sim_cfg_router.sv
module sim_cfg_router;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [3:0]  ioBe = '0;
  logic [31:0] ioWdata = '0;
  logic        ioRd = 1'b0, ioWr = 1'b0;
  logic [31:0] ioRdata;
  logic [7:0]  secBus = 8'h02, subBus = 8'h05;
  logic        decValid, decWrite, ioPass;
  logic [2:0]  decTarget, decFunc;
  logic [7:0]  decBus;
  logic [4:0]  decDev;
  logic [5:0]  decReg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cfg_router u0 (.*);

  always #(ClkPeriod/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkAddr(bit en, logic [7:0] bus, logic [4:0] dev,
                                         logic [2:0] fn, logic [5:0] rg);
    return {en, 7'h00, bus, dev, fn, rg, 2'b00};
  endfunction

  // one-cycle strobe; returns at the next falling edge where registered results show
  task automatic ioCycle(logic [15:0] a, logic [3:0] be, bit wr, logic [31:0] d);
    @(negedge clk);
    ioAddr = a; ioBe = be; ioWdata = d; ioWr = wr; ioRd = !wr;
    @(negedge clk);
    ioWr = 0; ioRd = 0; ioBe = '0;
  endtask

  task automatic readAddr(output logic [31:0] v);
    @(negedge clk);
    ioAddr = 16'h0CF8; ioBe = 4'hF; ioRd = 1;
    #1 v = ioRdata;
    @(negedge clk);
    ioRd = 0; ioBe = '0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1 decValid", {31'b0, decValid}, 0);
    check("R1 ioPass", {31'b0, ioPass}, 0);
    readAddr(v);
    check("R1 addr reg", v, 0);
  endtask

  task automatic testAddrRw();
    logic [31:0] v;
    ioCycle(16'h0CF8, 4'hF, 1, 32'hFFFF_FFFF);
    readAddr(v);
    check("R2 reserved masked", v, 32'h80FF_FFFC);
    ioCycle(16'h0CF8, 4'hF, 1, 32'h0012_3454);
    readAddr(v);
    check("R2 readback", v, 32'h0012_3454);
  endtask

  task automatic testPartial();
    logic [31:0] v;
    ioCycle(16'h0CF8, 4'hF, 1, mkAddr(1, 8'h07, 5'd9, 3'd1, 6'd4));
    ioCycle(16'h0CF8, 4'h3, 1, 32'h0000_0000);
    check("R3 ioPass pulse", {31'b0, ioPass}, 1);
    check("R3 no decValid", {31'b0, decValid}, 0);
    @(negedge clk);
    check("R3 ioPass drops", {31'b0, ioPass}, 0);
    ioCycle(16'h0CF8, 4'h1, 0, 32'h0);
    check("R3 byte read pass", {31'b0, ioPass}, 1);
    readAddr(v);
    check("R3 reg unchanged", v, mkAddr(1, 8'h07, 5'd9, 3'd1, 6'd4));
  endtask

  task automatic testDisabled();
    ioCycle(16'h0CF8, 4'hF, 1, mkAddr(0, 8'h00, 5'd1, 3'd0, 6'd0));
    ioCycle(16'h0CFE, 4'h4, 1, 32'h0);
    check("R4 ioPass", {31'b0, ioPass}, 1);
    check("R4 no decValid", {31'b0, decValid}, 0);
  endtask

  task automatic cfgAccess(string tag, logic [7:0] bus, logic [4:0] dev, logic [2:0] fn,
                           logic [5:0] rg, bit wr, logic [2:0] expTgt);
    ioCycle(16'h0CF8, 4'hF, 1, mkAddr(1, bus, dev, fn, rg));
    ioCycle(16'h0CFC, 4'hF, wr, 32'hA5A5_0000);
    check({tag, " decValid"}, {31'b0, decValid}, 1);
    check({tag, " target"}, {29'b0, decTarget}, {29'b0, expTgt});
    check({tag, " ioPass"}, {31'b0, ioPass}, 0);
    check({tag, " R10 fields"}, {8'h0, decBus, 3'b0, decDev, 1'b0, decFunc, 2'b0, decReg},
          {8'h0, bus, 3'b0, dev, 1'b0, fn, 2'b0, rg});
    check({tag, " R10 write flag"}, {31'b0, decWrite}, {31'b0, wr});
    @(negedge clk);
    check({tag, " R10 pulse drops"}, {31'b0, decValid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testAddrRw();
    testPartial();
    testDisabled();
    cfgAccess("R5 dev0", 8'h00, 5'd0, 3'd0, 6'd0, 0, 3'd0);
    cfgAccess("R5 dev2", 8'h00, 5'd2, 3'd5, 6'd17, 1, 3'd0);
    cfgAccess("R6 dev3", 8'h00, 5'd3, 3'd0, 6'd1, 0, 3'd1);
    cfgAccess("R6 dev31", 8'h00, 5'd31, 3'd7, 6'd63, 1, 3'd1);
    cfgAccess("R7 below sec", 8'h01, 5'd4, 3'd2, 6'd8, 0, 3'd2);
    cfgAccess("R7 above sub", 8'h06, 5'd0, 3'd0, 6'd2, 1, 3'd2);
    cfgAccess("R8 eq sec", 8'h02, 5'd0, 3'd0, 6'd0, 0, 3'd3);
    cfgAccess("R9 sec+1", 8'h03, 5'd1, 3'd1, 6'd5, 1, 3'd4);
    cfgAccess("R9 eq sub", 8'h05, 5'd6, 3'd3, 6'd9, 0, 3'd4);
    secBus = 8'h04; subBus = 8'h04;
    cfgAccess("R7 range moved", 8'h03, 5'd0, 3'd0, 6'd0, 0, 3'd2);
    cfgAccess("R8 range moved", 8'h04, 5'd0, 3'd0, 6'd0, 1, 3'd3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule